// File: doc/BRIEF.md
# Split-Panel LCD Scan Timing Controller

This block generates the scan timing for a 640x200 monochrome passive LCD whose rows are split into an upper and a lower half, each half fed by its own row driver. Pixels leave the block four at a time on a 4-bit bus, paced by a column shift clock that runs at half the system clock. A column enable clock marks every sixteenth nibble. A row latch pulse closes each line, a frame start pulse marks line 0, and an AC drive level flips once per frame.

A logical scan line is 1280 pixels long: physical row r (160 nibbles) followed by physical row r+100 (160 nibbles), so 320 nibbles per line and 100 lines per frame. The block computes the frame-buffer read address for every nibble. The frame buffer sits outside the block and must return on `fb_data_i`, in the same cycle, the word at `fb_addr_o`. A display enable input starts and stops the whole scan. While it is low, every strobe is quiet and the counters sit at line 0, nibble 0.

Top module: `lcd_scan_ctrl`

## Requirements
- R1: `disp_on_o` follows `disp_en_i` one cycle later. While `disp_on_o` is low, `col_shift_o`, `col_ena_o`, `row_latch_o`, `frame_start_o`, `ac_drive_o`, `pix_o` and `fb_addr_o` are all zero, whatever `fb_data_i` carries.
- R2: Cycles are counted with k=0 as the first cycle in which `disp_on_o` is high. `col_shift_o` is low in even cycles and high in odd cycles. Nibble t=k/2 occupies cycles 2t and 2t+1.
- R3: `pix_o` is loaded at the clock edge where `col_shift_o` rises, with the `fb_data_i` value present in the preceding low cycle. It holds that value through the high cycle and the following low cycle. Before the first load it is 0.
- R4: For nibble n (0..319) of line r (0..99), `fb_addr_o` equals r*160+n when n<160, and (r+100)*160+(n-160) otherwise.
- R5: `col_enable_o` is high exactly in the high cycles of `col_shift_o` for nibbles with n mod 16 = 15, which gives 20 pulses per line.
- R6: A line has 320 shift pulses (640 clocks). `row_latch_o` is high for one cycle, in the low cycle right after the 320th shift pulse of a line, and never before the first line is complete.
- R7: A frame has 100 lines. `frame_start_o` is high for the whole of line 0, including the latch cycle that opens it, and low on lines 1..99.
- R8: `ac_drive_o` starts at 0 after enable and toggles at the edge where line 99 wraps to line 0.
- R9: Dropping the enable and raising it again restarts the scan at line 0, nibble 0 with `ac_drive_o` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| disp_en_i | input | 1 | Display enable request |
| fb_data_i | input | 4 | Frame-buffer word at `fb_addr_o`, same cycle |
| disp_on_o | output | 1 | Panel display enable |
| col_shift_o | output | 1 | Column shift clock (data latched on its falling edge) |
| col_ena_o | output | 1 | Column enable clock, once per 16 shifts |
| row_latch_o | output | 1 | Line latch pulse, also usable as row clock |
| frame_start_o | output | 1 | Frame start level, sampled on latch falling edge |
| ac_drive_o | output | 1 | AC drive level, toggles per frame |
| pix_o | output | 4 | Four consecutive pixels of one physical row |
| fb_addr_o | output | 15 | Frame-buffer read address |

## Verification
All outputs follow from registered counters. A change at the enable input therefore shows on every output one edge later, and k=0 is the first sampled cycle after that edge. For any later cycle k, the shift level, nibble, line, address, enable pulse and frame level are due in cycle k itself, while `pix_o` holds the word fetched for the previous low cycle. The latch and the AC flip appear in the cycle after the last shift of a line. The bench samples on the falling clock edge, and its expected values are a closed formula in k that counts these registers. Probe points are chosen at line, enable-group and frame boundaries, where an off-by-one cycle would change the result.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;

   typedef struct packed {
      logic shift;
      logic ena;
      logic latch;
      logic fstart;
      logic ac;
   } lcd_strobe_t;

   localparam lcd_strobe_t STROBE_IDLE = '{default: 1'b0};

endpackage

// File: rtl/lcd_scan_timer.sv
module lcd_scan_timer
   import lcd_scan_pkg::*;
#(
   parameter int NPR     = 160,
   parameter int HALVES  = 2,
   parameter int LINES   = 100,
   parameter int ENA_DIV = 16,
   localparam int NIBS   = NPR * HALVES,
   localparam int NW     = $clog2(NIBS),
   localparam int LW     = $clog2(LINES)
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   output logic [NW-1:0] nib_o,
   output logic [LW-1:0] line_o,
   output logic          load_o,
   output logic          line_adv_o,
   output logic          frame_wrap_o,
   output lcd_strobe_t   strb_o
);

   if (NIBS % ENA_DIV != 0) begin : g_bad_div
      $error("ENA_DIV must divide the nibbles per line");
   end
   if (LINES < 2 || NPR < 1) begin : g_bad_size
      $error("LINES must be at least 2 and NPR at least 1");
   end

   logic          ph_q;
   logic [NW-1:0] nib_q;
   logic [LW-1:0] line_q;
   logic          lp_q;
   logic          ac_q;
   logic          adv_nib, last_nib, adv_line, last_line, wrap;
   logic          ena_hit;

   assign adv_nib   = en & ph_q;
   assign last_nib  = (nib_q == NW'(NIBS - 1));
   assign adv_line  = adv_nib & last_nib;
   assign last_line = (line_q == LW'(LINES - 1));
   assign wrap      = adv_line & last_line;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q   <= 1'b0;
         nib_q  <= '0;
         line_q <= '0;
         lp_q   <= 1'b0;
         ac_q   <= 1'b0;
      end else if (!en) begin
         ph_q   <= 1'b0;
         nib_q  <= '0;
         line_q <= '0;
         lp_q   <= 1'b0;
         ac_q   <= 1'b0;
      end else begin
         ph_q <= ~ph_q;
         lp_q <= adv_line;
         if (adv_nib)
            nib_q <= last_nib ? '0 : nib_q + 1'b1;
         if (adv_line)
            line_q <= last_line ? '0 : line_q + 1'b1;
         if (wrap)
            ac_q <= ~ac_q;
      end
   end

   // enable-pulse decode: cheap bit test for a power-of-two divider
   if ((ENA_DIV & (ENA_DIV - 1)) == 0 && ENA_DIV > 1) begin : g_ena_pow2
      localparam int EW = $clog2(ENA_DIV);
      assign ena_hit = &nib_q[EW-1:0];
   end else begin : g_ena_mod
      assign ena_hit = ((nib_q % NW'(ENA_DIV)) == NW'(ENA_DIV - 1));
   end

   always_comb begin
      strb_o        = STROBE_IDLE;
      strb_o.shift  = en & ph_q;
      strb_o.ena    = en & ph_q & ena_hit;
      strb_o.latch  = en & lp_q;
      strb_o.fstart = en & (line_q == '0);
      strb_o.ac     = en & ac_q;
   end

   assign nib_o        = nib_q;
   assign line_o       = line_q;
   assign load_o       = en & ~ph_q;
   assign line_adv_o   = adv_line;
   assign frame_wrap_o = wrap;

   AST_NIB_RANGE:  assert property (@(posedge clk) disable iff (!rst_n)
      nib_q < NW'(NIBS)) else $error("nibble out of range");   // R6
   AST_LINE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      line_q < LW'(LINES)) else $error("line out of range");   // R7
   AST_LATCH_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      lp_q |=> !lp_q) else $error("latch longer than one cycle"); // R6

endmodule

// File: rtl/lcd_scan_addr.sv
module lcd_scan_addr #(
   parameter int NPR        = 160,
   parameter int LINES      = 100,
   parameter int ROW_OFFSET = 100,
   parameter bit INC_STYLE  = 1'b1,
   localparam int NIBS      = NPR * 2,
   localparam int NW        = $clog2(NIBS),
   localparam int LW        = $clog2(LINES),
   localparam int DEPTH     = (ROW_OFFSET + LINES) * NPR,
   localparam int AW        = $clog2(DEPTH)
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic [NW-1:0] nib,
   input  logic [LW-1:0] line,
   input  logic          line_adv,
   input  logic          frame_wrap,
   output logic [AW-1:0] addr_o
);

   if (ROW_OFFSET < LINES) begin : g_bad_ofs
      $error("ROW_OFFSET must not overlap the first half rows");
   end

   logic          upper;
   logic [AW-1:0] nib_ext;
   logic [AW-1:0] addr_raw;

   assign upper   = (nib < NW'(NPR));
   assign nib_ext = AW'(nib);

   if (INC_STYLE) begin : g_inc
      // running row base replaces a line-by-NPR multiplier
      logic [AW-1:0] base_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            base_q <= '0;
         else if (!en || frame_wrap)
            base_q <= '0;
         else if (line_adv)
            base_q <= base_q + AW'(NPR);
      end
      assign addr_raw = upper ? base_q + nib_ext
                              : base_q + nib_ext + AW'(ROW_OFFSET * NPR - NPR);

      AST_BASE_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
         en |-> base_q == AW'(line) * AW'(NPR)) else $error("row base drift"); // R4
   end else begin : g_mul
      logic [AW-1:0] row_sel;
      logic [AW-1:0] col_sel;
      assign row_sel  = upper ? AW'(line) : AW'(line) + AW'(ROW_OFFSET);
      assign col_sel  = upper ? nib_ext : nib_ext - AW'(NPR);
      assign addr_raw = row_sel * AW'(NPR) + col_sel;
   end

   assign addr_o = en ? addr_raw : '0;

   AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      addr_o < AW'(DEPTH)) else $error("address beyond buffer");  // R4

endmodule

// File: rtl/lcd_scan_pixel.sv
module lcd_scan_pixel #(
   parameter int DW = 4
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic          load,
   input  logic [DW-1:0] d_i,
   output logic [DW-1:0] q_o
);

   if (DW < 1) begin : g_bad_dw
      $error("DW must be positive");
   end

   logic [DW-1:0] q_r;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q_r <= '0;
      else if (!en)
         q_r <= '0;
      else if (load)
         q_r <= d_i;
   end

   assign q_o = en ? q_r : '0;

   AST_PIX_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> q_o == '0) else $error("pixels while off");   // R1

endmodule

// File: rtl/lcd_scan_ctrl.sv
module lcd_scan_ctrl
   import lcd_scan_pkg::*;
#(
   parameter int DW         = 4,
   parameter int NPR        = 160,
   parameter int LINES      = 100,
   parameter int ROW_OFFSET = 100,
   parameter int ENA_DIV    = 16,
   parameter bit INC_STYLE  = 1'b1,
   localparam int NIBS      = NPR * 2,
   localparam int NW        = $clog2(NIBS),
   localparam int LW        = $clog2(LINES),
   localparam int AW        = $clog2((ROW_OFFSET + LINES) * NPR)
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          disp_en_i,
   input  logic [DW-1:0] fb_data_i,
   output logic          disp_on_o,
   output logic          col_shift_o,
   output logic          col_ena_o,
   output logic          row_latch_o,
   output logic          frame_start_o,
   output logic          ac_drive_o,
   output logic [DW-1:0] pix_o,
   output logic [AW-1:0] fb_addr_o
);

   logic          en_q;
   logic [NW-1:0] nib;
   logic [LW-1:0] line;
   logic          load, line_adv, frame_wrap;
   lcd_strobe_t   strb;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en_q <= 1'b0;
      else        en_q <= disp_en_i;
   end

   lcd_scan_timer #(
      .NPR(NPR), .HALVES(2), .LINES(LINES), .ENA_DIV(ENA_DIV)
   ) u_timer (
      .clk(clk), .rst_n(rst_n), .en(en_q),
      .nib_o(nib), .line_o(line), .load_o(load),
      .line_adv_o(line_adv), .frame_wrap_o(frame_wrap), .strb_o(strb)
   );

   lcd_scan_addr #(
      .NPR(NPR), .LINES(LINES), .ROW_OFFSET(ROW_OFFSET), .INC_STYLE(INC_STYLE)
   ) u_addr (
      .clk(clk), .rst_n(rst_n), .en(en_q), .nib(nib), .line(line),
      .line_adv(line_adv), .frame_wrap(frame_wrap), .addr_o(fb_addr_o)
   );

   lcd_scan_pixel #(.DW(DW)) u_pix (
      .clk(clk), .rst_n(rst_n), .en(en_q), .load(load),
      .d_i(fb_data_i), .q_o(pix_o)
   );

   assign disp_on_o     = en_q;
   assign col_shift_o   = strb.shift;
   assign col_ena_o     = strb.ena;
   assign row_latch_o   = strb.latch;
   assign frame_start_o = strb.fstart;
   assign ac_drive_o    = strb.ac;

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !disp_on_o |-> !(col_shift_o | col_ena_o | row_latch_o | frame_start_o | ac_drive_o))
      else $error("strobe while off");                                   // R1
   AST_SHIFT_ALTERNATES: assert property (@(posedge clk) disable iff (!rst_n)
      disp_on_o && $past(disp_on_o) |-> col_shift_o != $past(col_shift_o))
      else $error("shift clock not at half rate");                       // R2
   AST_PIX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      disp_on_o && !col_shift_o && $past(col_shift_o) |-> $stable(pix_o))
      else $error("pixels moved on falling shift");                      // R3
   AST_ENA_IN_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
      col_ena_o |-> col_shift_o) else $error("enable outside shift");    // R5
   AST_LATCH_AFTER_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
      row_latch_o |-> !col_shift_o && $past(col_shift_o))
      else $error("latch misplaced");                                    // R6
   AST_AC_AT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      disp_on_o && $past(disp_on_o) && !$stable(ac_drive_o) |-> frame_start_o && row_latch_o)
      else $error("ac flip away from frame start");                      // R8

endmodule

// File: tb/lcd_scan_ctrl_bench.sv
module lcd_scan_ctrl_bench;

   localparam int NPR   = 160;
   localparam int NIBS  = 320;
   localparam int LINES = 100;
   localparam int LINE_CYC  = 2 * NIBS;
   localparam int FRAME_CYC = LINE_CYC * LINES;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        disp_en_i = 1'b0;
   logic [3:0]  fb_data_i;
   logic        disp_on_o, col_shift_o, col_ena_o, row_latch_o, frame_start_o, ac_drive_o;
   logic [3:0]  pix_o;
   logic [14:0] fb_addr_o;

   int checks = 0;
   int errors = 0;
   int kcur   = 0;
   int cycles = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   function automatic logic [3:0] fbword(input logic [14:0] a);
      return a[3:0] ^ a[7:4] ^ a[11:8] ^ {1'b0, a[14:12]};
   endfunction

   // independent model of the fetch mapping, R4
   function automatic int exp_addr(input int t);
      int n = t % NIBS;
      int r = (t / NIBS) % LINES;
      return (n < NPR) ? r * NPR + n : (r + 100) * NPR + (n - NPR);
   endfunction

   // bench frame buffer
   assign fb_data_i = fbword(fb_addr_o);

   lcd_scan_ctrl u_lcd_scan_ctrl (
      .clk(clk), .rst_n(rst_n), .disp_en_i(disp_en_i), .fb_data_i(fb_data_i),
      .disp_on_o(disp_on_o), .col_shift_o(col_shift_o), .col_ena_o(col_ena_o),
      .row_latch_o(row_latch_o), .frame_start_o(frame_start_o),
      .ac_drive_o(ac_drive_o), .pix_o(pix_o), .fb_addr_o(fb_addr_o)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d (k=%0d)", req, what, act, exp, kcur);
      end
   endtask

   task automatic goto_k(input int k);
      repeat (k - kcur) @(negedge clk);
      kcur = k;
   endtask

   // compare every output with the closed formula for cycle k
   task automatic check_k(input int k);
      int ph, t, n, r;
      goto_k(k);
      ph = k % 2; t = k / 2; n = t % NIBS; r = (t / NIBS) % LINES;
      chk("R1", "disp_on", int'(disp_on_o), 1);
      chk("R2", "col_shift", int'(col_shift_o), ph);
      chk("R4", "fb_addr", int'(fb_addr_o), exp_addr(t));
      chk("R5", "col_ena", int'(col_ena_o), (ph == 1 && n % 16 == 15) ? 1 : 0);
      chk("R6", "row_latch", int'(row_latch_o), (ph == 0 && n == 0 && t >= NIBS) ? 1 : 0);
      chk("R7", "frame_start", int'(frame_start_o), (r == 0) ? 1 : 0);
      chk("R8", "ac_drive", int'(ac_drive_o), (t / (NIBS * LINES)) % 2);
      if (k == 0)
         chk("R3", "pix", int'(pix_o), 0);
      else if (ph == 1)
         chk("R3", "pix", int'(pix_o), int'(fbword(15'(exp_addr(t)))));
      else
         chk("R3", "pix", int'(pix_o), int'(fbword(15'(exp_addr(t - 1)))));
   endtask

   task automatic check_idle(input string req);
      chk(req, "disp_on idle", int'(disp_on_o), 0);
      chk(req, "strobes idle",
          int'({col_shift_o, col_ena_o, row_latch_o, frame_start_o, ac_drive_o}), 0);
      chk(req, "pix idle", int'(pix_o), 0);
      chk(req, "addr idle", int'(fb_addr_o), 0);
   endtask

   task automatic enable_scan();
      disp_en_i = 1'b1;
      @(negedge clk);
      kcur = 0;
   endtask

   // probe points within one frame: nibble edges, enable groups, half and line boundaries
   localparam int NPROBE = 20;
   localparam int PROBE [NPROBE] = '{
      0, 1, 2, 3, 30, 31, 32, 33, 318, 319, 320, 321,
      638, 639, 640, 641, 1279, 1280, 1281, 7000
   };

   always @(posedge clk) begin
      cycles++;
      if (cycles > 200000 && !done) begin
         errors++;
         $display("FAIL watchdog expired at cycle %0d", cycles);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_idle("R1");                       // R1 reset state

      // R1: enable low ignores frame-buffer data
      repeat (5) @(negedge clk);
      check_idle("R1");

      enable_scan();
      foreach (PROBE[i]) check_k(PROBE[i]);   // R2 R3 R4 R5 R6 R7

      // R7 R8: last line of frame and the wrap into the next frame
      check_k(FRAME_CYC - LINE_CYC);
      check_k(FRAME_CYC - 2);
      check_k(FRAME_CYC - 1);
      check_k(FRAME_CYC);
      check_k(FRAME_CYC + 1);
      check_k(FRAME_CYC + LINE_CYC);

      // R1 R9: drop enable, then restart from line 0
      disp_en_i = 1'b0;
      @(negedge clk);
      check_idle("R9");
      repeat (4) @(negedge clk);
      check_idle("R1");
      enable_scan();
      check_k(0);                              // R9 restart, ac back to 0
      check_k(1);
      check_k(LINE_CYC);
      check_k(LINE_CYC + 321);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule